// File: doc/BRIEF.md
# Four-Level FSK Polyphase Modulator

This block converts a stream of bytes into baseband samples for a four-level frequency-shift-keyed transmitter. Every accepted byte is cut into four 2-bit symbols, highest pair first. Each symbol becomes one of four signed amplitudes. A polyphase root-raised-cosine interpolator then shapes the symbols into ten output samples per symbol, so each byte produces forty samples in consecutive cycles.

Each byte arrives with a small marker word. The block emits that marker on exactly one sample of the byte's forty, the sample in the middle of the byte. All other samples carry a zero marker, so a downstream stage can line events up with the modulated waveform. The input handshake stalls while a byte is being emitted. The filter history carries over from byte to byte, so the waveform stays continuous across byte boundaries.

Top module: `fsk4_mod`

## Requirements
- R1: While reset is active, and in the first cycle after it: in_ready is 1, out_valid is 0, out_sample is 0 and out_mark is 0. Reset clears the symbol history to zero amplitude, so the first byte after reset is filtered as if silence came before it.
- R2: A byte is accepted at a rising clock edge where in_valid and in_ready are both 1. From that edge, in_ready stays 0 until the edge that registers the byte's fortieth sample.
- R3: in_byte, in_mark and in_valid are ignored while in_ready is 0. Such a stalled offer never shows up in any later sample or marker.
- R4: The four symbols of a byte are taken from bit pairs [7:6], [5:4], [3:2] and [1:0], in that order.
- R5: The symbol-to-amplitude map is: pair 2'b11 gives +1362, 2'b10 gives +454, 2'b00 gives -454, and 2'b01 gives -1362.
- R6: The first sample is registered at the clock edge after the accepting edge. out_valid is then 1 for exactly 40 consecutive cycles.
- R7: Sample p (0..9) of symbol k is the sum over j = 0..8 of c[p + 10*j] * a[k-j]. Here a[k] is the amplitude of the newest symbol, a[k-j] is the amplitude j symbols earlier, and c is the 90-tap coefficient set. In c, taps 0..8 are zero, c[49] = 32767, and c[n] = c[98-n] for n > 49.
- R8: The sum is kept at full precision. The block adds 2^14, shifts right arithmetically by 15 and clamps the result to [-32768, 32767].
- R9: out_mark equals the byte's in_mark on sample index 20 (counting from 0) of its forty samples, and is 0 on every other cycle.
- R10: Symbol history is not cleared between bytes. The first samples of a byte depend on the last eight symbols of the bytes before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_byte | input | 8 | Packed four-symbol byte |
| in_mark | input | MARK_W | Marker word carried with the byte |
| in_valid | input | 1 | Byte offer |
| in_ready | output | 1 | Block can take a byte this cycle |
| out_sample | output | 16 | Signed Q15 baseband sample |
| out_mark | output | MARK_W | Byte marker on its middle sample, zero otherwise |
| out_valid | output | 1 | out_sample holds a new sample |

## Verification
Some rules are checked by the bound checker on every cycle:
- an accepted byte drops in_ready on the next edge;
- a valid burst always begins two edges after an acceptance;
- a valid burst never runs longer or shorter than forty samples;
- a non-zero marker only ever appears on sample twenty of a burst.

The sample values can only be shown by the bench's scenarios, which compare them against a reference filter model. These cover the symbol order, the amplitude map, the coefficient layout, the rounding, history carried across bytes, history cleared by a mid-stream reset, and bytes offered during a stall.

// File: rtl/fsk4_pkg.sv
package fsk4_pkg;
    localparam int SAMPLE_W      = 16;
    localparam int COEF_W        = 16;
    localparam int BYTE_W        = 8;
    localparam int TAPS          = 90;
    localparam int INTERP        = 10;
    localparam int PHASE_LEN     = TAPS / INTERP;
    localparam int SYMS_PER_BYTE = BYTE_W / 2;
    localparam int FRAC          = 15;
    localparam int LEVEL_OUTER   = 1362;
    localparam int LEVEL_INNER   = 454;

    // Root-raised-cosine taps, roll-off 0.2, eight-symbol span, unity peak.
    // Only the rising half is stored; the rest mirrors about tap 49.
    function automatic logic signed [COEF_W-1:0] tap_coef(input int n);
        int k;
        int v;
        k = (n > (TAPS / 2 + 4)) ? (TAPS + 8 - n) : n;
        case (k)
            9:  v = 850;    10: v = 592;    11: v = 219;    12: v = -234;
            13: v = -720;   14: v = -1179;  15: v = -1548;  16: v = -1769;
            17: v = -1795;  18: v = -1597;  19: v = -1172;  20: v = -544;
            21: v = 237;    22: v = 1092;   23: v = 1927;   24: v = 2637;
            25: v = 3120;   26: v = 3286;   27: v = 3073;   28: v = 2454;
            29: v = 1447;   30: v = 116;    31: v = -1431;  32: v = -3043;
            33: v = -4544;  34: v = -5739;  35: v = -6442;  36: v = -6483;
            37: v = -5735;  38: v = -4121;  39: v = -1633;  40: v = 1669;
            41: v = 5651;   42: v = 10118;  43: v = 14822;  44: v = 19484;
            45: v = 23810;  46: v = 27520;  47: v = 30367;  48: v = 32156;
            49: v = 32767;
            default: v = 0;
        endcase
        return v[COEF_W-1:0];
    endfunction
endpackage

// File: rtl/fsk4_symbol_map.sv
module fsk4_symbol_map
    import fsk4_pkg::*;
(
    input  logic [1:0]                 dibit,
    output logic signed [SAMPLE_W-1:0] level
);
    always_comb begin
        case (dibit)
            2'b11:   level = SAMPLE_W'(LEVEL_OUTER);
            2'b10:   level = SAMPLE_W'(LEVEL_INNER);
            2'b00:   level = SAMPLE_W'(-LEVEL_INNER);
            default: level = SAMPLE_W'(-LEVEL_OUTER);
        endcase
    end
endmodule

// File: rtl/fsk4_delay_line.sv
module fsk4_delay_line
    import fsk4_pkg::*;
#(
    parameter int DEPTH = PHASE_LEN,
    parameter int W     = SAMPLE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [W-1:0]       din,
    output logic [DEPTH*W-1:0] taps_flat
);
    logic [DEPTH*W-1:0] line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (push) begin
            line_d = {line_q[(DEPTH-1)*W-1:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign taps_flat = line_q;
endmodule

// File: rtl/fsk4_phase_mac.sv
module fsk4_phase_mac
    import fsk4_pkg::*;
#(
    parameter int DEPTH = PHASE_LEN,
    parameter int PH_W  = $clog2(INTERP)
) (
    input  logic [PH_W-1:0]            phase,
    input  logic [DEPTH*SAMPLE_W-1:0]  taps_flat,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int PROD_W = COEF_W + SAMPLE_W;
    localparam int ACC_W  = PROD_W + $clog2(DEPTH) + 1;
    localparam logic signed [ACC_W-1:0] HALF_LSB = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((2 ** (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

    logic signed [PROD_W-1:0] prod [DEPTH];

    for (genvar j = 0; j < DEPTH; j++) begin : g_tap
        logic signed [COEF_W-1:0]   c_j;
        logic signed [SAMPLE_W-1:0] a_j;
        always_comb begin
            c_j     = tap_coef(int'(phase) + INTERP * j);
            a_j     = $signed(taps_flat[j*SAMPLE_W +: SAMPLE_W]);
            prod[j] = c_j * a_j;
        end
    end

    logic signed [ACC_W-1:0] acc, rnd, shifted;

    always_comb begin
        acc = '0;
        for (int j = 0; j < DEPTH; j++) begin
            acc = acc + ACC_W'(prod[j]);
        end
        rnd     = acc + HALF_LSB;
        shifted = rnd >>> FRAC;
        if (shifted > MAXV)      sample = MAXV[SAMPLE_W-1:0];
        else if (shifted < MINV) sample = MINV[SAMPLE_W-1:0];
        else                     sample = shifted[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/fsk4_mod.sv
module fsk4_mod
    import fsk4_pkg::*;
#(
    parameter int MARK_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   in_byte,
    input  logic [MARK_W-1:0]   in_mark,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic [MARK_W-1:0]   out_mark,
    output logic                out_valid
);
    localparam int SYM_W        = $clog2(SYMS_PER_BYTE);
    localparam int PH_W         = $clog2(INTERP);
    localparam int SAMPLES_BYTE = SYMS_PER_BYTE * INTERP;
    localparam int MARK_POS     = SAMPLES_BYTE / 2;

    typedef struct packed {
        logic                busy;
        logic [SYM_W-1:0]    sym;
        logic [PH_W-1:0]     phase;
        logic [BYTE_W-1:0]   rest;
        logic [MARK_W-1:0]   mark;
        logic [SAMPLE_W-1:0] sample;
        logic [MARK_W-1:0]   omark;
        logic                ovalid;
    } state_t;

    state_t st_d, st_q;

    logic                          push_d;
    logic [1:0]                    dibit_d;
    logic signed [SAMPLE_W-1:0]    level;
    logic [PHASE_LEN*SAMPLE_W-1:0] taps_flat;
    logic signed [SAMPLE_W-1:0]    mac_out;

    fsk4_symbol_map u_map (
        .dibit (dibit_d),
        .level (level)
    );

    fsk4_delay_line #(.DEPTH(PHASE_LEN), .W(SAMPLE_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_d),
        .din       (level),
        .taps_flat (taps_flat)
    );

    fsk4_phase_mac #(.DEPTH(PHASE_LEN), .PH_W(PH_W)) u_mac (
        .phase     (st_q.phase),
        .taps_flat (taps_flat),
        .sample    (mac_out)
    );

    always_comb begin
        int idx;
        st_d        = st_q;
        st_d.ovalid = 1'b0;
        st_d.omark  = '0;
        push_d      = 1'b0;
        dibit_d     = in_byte[BYTE_W-1 -: 2];
        idx         = int'(st_q.sym) * INTERP + int'(st_q.phase);

        if (!st_q.busy) begin
            if (in_valid) begin
                push_d     = 1'b1;
                st_d.busy  = 1'b1;
                st_d.sym   = '0;
                st_d.phase = '0;
                st_d.rest  = {in_byte[BYTE_W-3:0], 2'b00};
                st_d.mark  = in_mark;
            end
        end else begin
            st_d.ovalid = 1'b1;
            st_d.sample = mac_out;
            st_d.omark  = (idx == MARK_POS) ? st_q.mark : '0;
            if (st_q.phase == PH_W'(INTERP - 1)) begin
                st_d.phase = '0;
                if (st_q.sym == SYM_W'(SYMS_PER_BYTE - 1)) begin
                    st_d.busy = 1'b0;
                end else begin
                    st_d.sym  = st_q.sym + SYM_W'(1);
                    push_d    = 1'b1;
                    dibit_d   = st_q.rest[BYTE_W-1 -: 2];
                    st_d.rest = {st_q.rest[BYTE_W-3:0], 2'b00};
                end
            end else begin
                st_d.phase = st_q.phase + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready   = !st_q.busy;
    assign out_sample = st_q.sample;
    assign out_mark   = st_q.omark;
    assign out_valid  = st_q.ovalid;
endmodule

// File: rtl/fsk4_mod_chk.sv
module fsk4_mod_chk #(
    parameter int MARK_W   = 3,
    parameter int SAMPLES  = 40,
    parameter int MARK_POS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic [MARK_W-1:0] out_mark
);
    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (out_valid) run_q <= run_q + 8'd1;
        else                run_q <= '0;
    end

    p_accept_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_burst_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));

    p_burst_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run_q < 8'(SAMPLES)));

    p_burst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && run_q != 8'd0) |-> (run_q == 8'(SAMPLES)));

    p_mark_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mark != '0) |-> (out_valid && run_q == 8'(MARK_POS)));
endmodule

bind fsk4_mod fsk4_mod_chk #(.MARK_W(MARK_W), .SAMPLES(40), .MARK_POS(20)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_mark  (out_mark)
);

// File: tb/sim_fsk4_mod.sv
module sim_fsk4_mod;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [7:0]    in_byte;
    logic [MW-1:0] in_mark;
    logic          in_valid;
    logic          in_ready;
    logic [15:0]   out_sample;
    logic [MW-1:0] out_mark;
    logic          out_valid;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    int hist [9];
    int half [41] = '{850, 592, 219, -234, -720, -1179, -1548, -1769, -1795,
                      -1597, -1172, -544, 237, 1092, 1927, 2637, 3120, 3286,
                      3073, 2454, 1447, 116, -1431, -3043, -4544, -5739, -6442,
                      -6483, -5735, -4121, -1633, 1669, 5651, 10118, 14822,
                      19484, 23810, 27520, 30367, 32156, 32767};

    always #4 clk = ~clk;

    fsk4_mod #(.MARK_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_mark(in_mark),
        .in_valid(in_valid), .in_ready(in_ready), .out_sample(out_sample),
        .out_mark(out_mark), .out_valid(out_valid)
    );

    function automatic int ref_level(input bit [1:0] d);
        case (d)
            2'b11:   return 1362;
            2'b10:   return 454;
            2'b00:   return -454;
            default: return -1362;
        endcase
    endfunction

    function automatic int ref_coef(input int n);
        int k;
        k = (n > 49) ? 98 - n : n;
        if (k < 9) return 0;
        return half[k-9];
    endfunction

    function automatic int ref_sample(input int p);
        longint acc;
        acc = 0;
        for (int j = 0; j < 9; j++) acc += longint'(ref_coef(p + 10*j)) * hist[j];
        acc = (acc + 16384) >>> 15;
        if (acc > 32767) acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic clear_hist();
        for (int j = 0; j < 9; j++) hist[j] = 0;
    endtask

    task automatic send_byte(input bit [7:0] b, input bit [MW-1:0] m,
                             input bit junk, input string tag);
        int exp [40];
        bit [7:0] r;
        int w;
        w = 0;
        while (!in_ready && w < 100) begin @(negedge clk); w++; end
        r = b;
        for (int s = 0; s < 4; s++) begin
            for (int j = 8; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = ref_level(r[7:6]);
            r = r << 2;
            for (int p = 0; p < 10; p++) exp[s*10 + p] = ref_sample(p);
        end
        in_byte = b; in_mark = m; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, "/R2 ready drop"}, int'(in_ready), 0);
        check({tag, "/R6 no early valid"}, int'(out_valid), 0);
        if (junk) begin
            in_byte = ~b; in_mark = MW'($urandom); in_valid = 1'b1;
        end
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            check({tag, "/R6 valid"}, int'(out_valid), 1);
            check(tag, int'($signed(out_sample)), exp[k]);
            check({tag, "/R9 mark"}, int'(out_mark), (k == 20) ? int'(m) : 0);
            if (k < 39) check({tag, "/R2 stall"}, int'(in_ready), 0);
            if (k == 29) in_valid = 1'b0;
        end
        @(negedge clk);
        check({tag, "/R6 burst end"}, int'(out_valid), 0);
        check({tag, "/R2 ready back"}, int'(in_ready), 1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_mark = '0;
        clear_hist();
        repeat (3) @(negedge clk);
        check("R1 ready", int'(in_ready), 1);
        check("R1 valid", int'(out_valid), 0);
        check("R1 sample", int'(out_sample), 0);
        check("R1 mark", int'(out_mark), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after", int'(out_valid), 0);

        send_byte(8'hFF, 3'd5, 1'b0, "R1 silence then R5 +outer");
        send_byte(8'hAA, 3'd1, 1'b0, "R5 +inner");
        send_byte(8'h00, 3'd2, 1'b0, "R5 -inner");
        send_byte(8'h55, 3'd7, 1'b0, "R5 -outer");
        send_byte(8'hE4, 3'd3, 1'b0, "R4 order 11-10-01-00");
        send_byte(8'h1B, 3'd6, 1'b0, "R4 order 00-01-10-11");
        send_byte(8'hCC, 3'd4, 1'b0, "R8 rounding alt swing");
        send_byte(8'h33, 3'd0, 1'b0, "R10 history carry");
        send_byte(8'h5F, 3'd2, 1'b1, "R3 stalled offer");
        send_byte(8'h0F, 3'd1, 1'b1, "R3 stalled offer 2");

        for (int i = 0; i < 30; i++) begin
            send_byte(8'($urandom), MW'($urandom), 1'($urandom), "R7 random");
        end

        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset valid", int'(out_valid), 0);
        check("R1 mid reset ready", int'(in_ready), 1);
        rst_n = 1'b1;
        clear_hist();
        @(negedge clk);
        send_byte(8'hFF, 3'd5, 1'b0, "R1 history cleared");
        send_byte(8'h9C, 3'd6, 1'b0, "R10 after reset");

        done = 1;
        finish_run();
    end
endmodule